// File: doc/BRIEF.md
# Transmitter Supervision and Error Signaling

This block sits between a protocol controller and the analog stage of a differential bus transceiver. It decides when the transmitter may drive the bus, picks the bus symbol to drive, and drives an active-low error/wake indication pin. It keeps single-bit condition flags for a transmit-enable timeout, thermal shutdown, bus error, two supply undervoltages and a serial-readout error. These flags are merged into a common error flag.

A host selects normal operation with a mode request input. Undervoltage on either supply forces standby. The indication pin reports either the common error flag or a wake flag, depending on the mode request. Error reporting starts in latched mode. In latched mode, per-flag status bits stay set until the host completes a correctly formed read frame on the chip-select and clock pins. Holding chip-select low with the clock high for long enough switches the block to track mode for good. In track mode, the pin follows the live flags, and each indication is held for a minimum time. All long timers count pulses of a 1 MHz timebase tick.

Top module: `txsup_top`

## Requirements
- R1: After reset, tx_ready is 0, tx_sym is 0, err_n is 1 and track_sel is 0, so latched reporting is the default.
- R2: Normal operation means mode_req is high and neither uv_vcc nor uv_vio is set. tx_ready is 1 only while all of these hold: normal operation, guard_en high, the timeout flag clear and the thermal flag clear.
- R3: tx_sym encodes the driven symbol: 0 is low-power idle, 1 is idle, 2 is data_0 and 3 is data_1. Outside normal operation it is 0. When the transmitter is not ready or tx_en_n is high it is 1. Otherwise it follows tx_data (0 gives 2, 1 gives 3).
- R4: A transmission never starts with data_1. After idle, tx_sym stays 1 while tx_data is 1, until tx_data first goes to 0.
- R5: The timeout flag sets when tx_en_n stays low in normal operation for TOUT_US ticks. While it is set, tx_ready is 0. It clears when tx_en_n goes high or normal operation is left.
- R6: The thermal flag sets while over_temp is high in normal operation. Once set, it clears only when over_temp is low and tx_en_n is high, or when normal operation is left.
- R7: While the transmitter is enabled (tx_ready and tx_en_n low), the bus error flag is re-evaluated SMP_DLY cycles after each tx_data edge. It sets if rx_data differs from tx_data and clears if they match. A change of rx_data with no tx_data edge has no effect. The flag also clears on tx_en_n high or on leaving normal operation. It never changes tx_ready or tx_sym.
- R8: err_n is active low. With mode_req high it shows the inverted common error flag. With mode_req low it shows the inverted wake_in.
- R9: In latched mode, each flag sets its own status bit, and the common error flag is the OR of the status bits. A correct frame clears every status bit whose flag is clear. A correct frame means: cs_n falls with sck low, exactly FRAME_BITS falling sck edges occur while cs_n is low, and cs_n rises with sck low.
- R10: In latched mode, an incorrect frame sets the serial error flag when cs_n rises. That flag clears on the next cs_n fall or on entry to track mode.
- R11: Holding cs_n low and sck high for STRAP_US ticks while uv_vio is low selects track mode. track_sel then reads 1 and stays 1 until reset.
- R12: In track mode, the common error flag is the OR of the live flags and clears without any frame. Once raised, it stays raised for at least HOLD_US ticks after the flags clear.
- R13: uv_vcc or uv_vio forces the block out of normal operation (tx_sym 0, tx_ready 0), and each counts as an error flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_us | input | 1 | One-cycle pulse, 1 MHz timebase |
| mode_req | input | 1 | High requests normal operation, low requests standby |
| tx_data | input | 1 | Transmit data from the controller |
| tx_en_n | input | 1 | Active-low transmit enable |
| guard_en | input | 1 | Bus guardian enable, low blocks the transmitter |
| rx_data | input | 1 | Received bus data |
| over_temp | input | 1 | Over-temperature alarm |
| uv_vcc | input | 1 | Filtered core supply undervoltage |
| uv_vio | input | 1 | Filtered I/O supply undervoltage |
| wake_in | input | 1 | Wake flag from the wakeup detector |
| cs_n | input | 1 | Serial chip select, active low |
| sck | input | 1 | Serial clock |
| tx_ready | output | 1 | Transmitter may drive |
| tx_sym | output | 2 | Symbol to drive (0 lp-idle, 1 idle, 2 data_0, 3 data_1) |
| err_n | output | 1 | Active-low error/wake indication |
| track_sel | output | 1 | Track reporting selected; switches the chip-select pull in the pad |

## Verification
The properties assume that all inputs are already synchronous to clk and change only between edges. They also assume that tick_us is a one-cycle pulse. The bench drives every input on the falling edge and generates the tick as a fixed pulse every other cycle. It holds serial clock and chip select steady for at least two cycles between edges, so that each sck falling edge and each cs_n edge is seen exactly once. wake_in is kept low while reset is applied, and undervoltage inputs are raised only as clean levels lasting many cycles.

// File: rtl/txsup_pkg.sv
package txsup_pkg;
  typedef enum logic [1:0] {
    SYM_IDLE_LP = 2'd0,
    SYM_IDLE    = 2'd1,
    SYM_DATA0   = 2'd2,
    SYM_DATA1   = 2'd3
  } bus_sym_e;

  // flag vector layout shared by the reporting logic
  localparam int NFLAG    = 6;
  localparam int FL_BUS   = 0;
  localparam int FL_THERM = 1;
  localparam int FL_TOUT  = 2;
  localparam int FL_UVCC  = 3;
  localparam int FL_UVIO  = 4;
  localparam int FL_SPI   = 5;
endpackage

// File: rtl/txsup_tick_timer.sv
// Saturating tick counter: expired is high once LIMIT ticks were seen while run
module txsup_tick_timer #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic run,
  output logic expired
);
  localparam int W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] LIM = W'(LIMIT);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (tick && cnt != LIM) cnt <= cnt + 1'b1;
  end

  assign expired = (cnt == LIM);
endmodule

// File: rtl/txsup_flags.sv
// Transmit-side condition flags, readiness and symbol selection
module txsup_flags
  import txsup_pkg::*;
#(
  parameter int TOUT_US = 1500,
  parameter int SMP_DLY = 2
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     tick_us,
  input  logic     normal,
  input  logic     tx_data,
  input  logic     tx_en_n,
  input  logic     guard_en,
  input  logic     rx_data,
  input  logic     over_temp,
  output logic     tout_q,
  output logic     therm_q,
  output logic     buserr_q,
  output logic     tx_ready_q,
  output bus_sym_e sym_q
);
  localparam int SW = $clog2(SMP_DLY + 1);

  logic          tout_exp;
  logic          tx_d;
  logic          started_q;
  logic          tx_on;
  logic          smp_now;
  logic [SW-1:0] smp_cnt;

  txsup_tick_timer #(.LIMIT(TOUT_US)) u_tout (
    .clk    (clk),
    .rst    (rst),
    .tick   (tick_us),
    .run    (normal & ~tx_en_n),
    .expired(tout_exp)
  );

  assign tx_on   = tx_ready_q & ~tx_en_n;
  assign smp_now = (smp_cnt == SW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_d       <= 1'b0;
      smp_cnt    <= '0;
      tout_q     <= 1'b0;
      therm_q    <= 1'b0;
      buserr_q   <= 1'b0;
      tx_ready_q <= 1'b0;
      started_q  <= 1'b0;
      sym_q      <= SYM_IDLE_LP;
    end else begin
      tx_d <= tx_data;
      // delay from a data edge to the bus comparison
      if (tx_data != tx_d) smp_cnt <= SW'(SMP_DLY);
      else if (smp_cnt != '0) smp_cnt <= smp_cnt - 1'b1;

      tout_q <= normal && !tx_en_n && (tout_q || tout_exp);

      if (!normal) therm_q <= 1'b0;
      else if (over_temp) therm_q <= 1'b1;
      else if (tx_en_n) therm_q <= 1'b0;

      if (!normal || tx_en_n) buserr_q <= 1'b0;
      else if (smp_now && tx_on) buserr_q <= (rx_data != tx_data);

      tx_ready_q <= normal & ~tout_q & guard_en & ~therm_q;
      started_q  <= tx_on && normal && (started_q || !tx_data);

      if (!normal) sym_q <= SYM_IDLE_LP;
      else if (!tx_on) sym_q <= SYM_IDLE;
      else if (started_q || !tx_data) sym_q <= tx_data ? SYM_DATA1 : SYM_DATA0;
      else sym_q <= SYM_IDLE;
    end
  end
endmodule

// File: rtl/txsup_report.sv
// Frame checking, reporting-mode strap, status latching and the indication pin
module txsup_report
  import txsup_pkg::*;
#(
  parameter int STRAP_US   = 200,
  parameter int HOLD_US    = 5,
  parameter int FRAME_BITS = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_us,
  input  logic             cs_n,
  input  logic             sck,
  input  logic             uv_vio,
  input  logic             mode_req,
  input  logic             wake_in,
  input  logic [NFLAG-2:0] flags_in,
  output logic             err_n_q,
  output logic             track_q
);
  localparam int CMAX = 2 * FRAME_BITS;
  localparam int CW   = $clog2(CMAX + 1);

  logic             cs_d, sck_d;
  logic             cs_fall, cs_rise, sck_fall;
  logic [CW-1:0]    edge_cnt;
  logic             bad_start;
  logic             frame_ok;
  logic             spi_q;
  logic [NFLAG-1:0] flags_all;
  logic [NFLAG-1:0] stat_q;
  logic             err_raw, err_q;
  logic             strap_exp, hold_exp;

  assign cs_fall  = cs_d & ~cs_n;
  assign cs_rise  = ~cs_d & cs_n;
  assign sck_fall = sck_d & ~sck;
  assign frame_ok = cs_rise & ~bad_start & ~sck & (edge_cnt == CW'(FRAME_BITS));

  assign flags_all = {spi_q, flags_in};
  assign err_raw   = track_q ? (|flags_all) : (|stat_q);

  txsup_tick_timer #(.LIMIT(STRAP_US)) u_strap (
    .clk    (clk),
    .rst    (rst),
    .tick   (tick_us),
    .run    (~cs_n & sck & ~uv_vio & ~track_q),
    .expired(strap_exp)
  );

  txsup_tick_timer #(.LIMIT(HOLD_US)) u_hold (
    .clk    (clk),
    .rst    (rst),
    .tick   (tick_us),
    .run    (track_q & err_q & ~err_raw),
    .expired(hold_exp)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_d      <= 1'b1;
      sck_d     <= 1'b0;
      edge_cnt  <= '0;
      bad_start <= 1'b0;
      spi_q     <= 1'b0;
      stat_q    <= '0;
      err_q     <= 1'b0;
      err_n_q   <= 1'b1;
      track_q   <= 1'b0;
    end else begin
      cs_d    <= cs_n;
      sck_d   <= sck;
      track_q <= track_q | strap_exp;

      if (cs_fall) edge_cnt <= '0;
      else if (!cs_n && sck_fall && edge_cnt != CW'(CMAX)) edge_cnt <= edge_cnt + 1'b1;

      if (cs_fall) bad_start <= sck;

      if (track_q || strap_exp) spi_q <= 1'b0;
      else if (cs_fall) spi_q <= 1'b0;
      else if (cs_rise && !frame_ok) spi_q <= 1'b1;

      // a correct frame keeps only the bits whose flag is still set
      if (frame_ok && !track_q) stat_q <= flags_all;
      else stat_q <= stat_q | flags_all;

      if (!track_q) err_q <= err_raw;
      else if (err_raw) err_q <= 1'b1;
      else if (hold_exp) err_q <= 1'b0;

      err_n_q <= mode_req ? ~err_q : ~wake_in;
    end
  end
endmodule

// File: rtl/txsup_top.sv
module txsup_top
  import txsup_pkg::*;
#(
  parameter int TOUT_US    = 1500,
  parameter int STRAP_US   = 200,
  parameter int HOLD_US    = 5,
  parameter int SMP_DLY    = 2,
  parameter int FRAME_BITS = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_us,
  input  logic       mode_req,
  input  logic       tx_data,
  input  logic       tx_en_n,
  input  logic       guard_en,
  input  logic       rx_data,
  input  logic       over_temp,
  input  logic       uv_vcc,
  input  logic       uv_vio,
  input  logic       wake_in,
  input  logic       cs_n,
  input  logic       sck,
  output logic       tx_ready,
  output logic [1:0] tx_sym,
  output logic       err_n,
  output logic       track_sel
);
  logic             normal_q;
  logic             tout_w, therm_w, buserr_w;
  bus_sym_e         sym_w;
  logic [NFLAG-2:0] flags_w;

  always_ff @(posedge clk) begin
    if (rst) normal_q <= 1'b0;
    else normal_q <= mode_req & ~uv_vcc & ~uv_vio;
  end

  txsup_flags #(.TOUT_US(TOUT_US), .SMP_DLY(SMP_DLY)) u_flags (
    .clk       (clk),
    .rst       (rst),
    .tick_us   (tick_us),
    .normal    (normal_q),
    .tx_data   (tx_data),
    .tx_en_n   (tx_en_n),
    .guard_en  (guard_en),
    .rx_data   (rx_data),
    .over_temp (over_temp),
    .tout_q    (tout_w),
    .therm_q   (therm_w),
    .buserr_q  (buserr_w),
    .tx_ready_q(tx_ready),
    .sym_q     (sym_w)
  );

  always_comb begin
    flags_w           = '0;
    flags_w[FL_BUS]   = buserr_w;
    flags_w[FL_THERM] = therm_w;
    flags_w[FL_TOUT]  = tout_w;
    flags_w[FL_UVCC]  = uv_vcc;
    flags_w[FL_UVIO]  = uv_vio;
  end

  assign tx_sym = sym_w;

  txsup_report #(.STRAP_US(STRAP_US), .HOLD_US(HOLD_US), .FRAME_BITS(FRAME_BITS)) u_report (
    .clk     (clk),
    .rst     (rst),
    .tick_us (tick_us),
    .cs_n    (cs_n),
    .sck     (sck),
    .uv_vio  (uv_vio),
    .mode_req(mode_req),
    .wake_in (wake_in),
    .flags_in(flags_w),
    .err_n_q (err_n),
    .track_q (track_sel)
  );
endmodule

// File: rtl/txsup_chk.sv
module txsup_chk (
  input logic       clk,
  input logic       rst,
  input logic       mode_req,
  input logic       guard_en,
  input logic       wake_in,
  input logic       tx_ready,
  input logic [1:0] tx_sym,
  input logic       err_n,
  input logic       track_sel,
  input logic       tout_flag
);
  // R2
  ready_guard_chk: assert property (@(posedge clk) disable iff (rst)
    tx_ready |-> ($past(guard_en) && $past(mode_req, 2)));

  // R3
  standby_sym_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_sym != 2'd0) |-> $past(mode_req, 2));

  // R4
  data1_start_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_sym == 2'd3) |-> ($past(tx_sym) == 2'd2 || $past(tx_sym) == 2'd3));

  // R5
  tout_block_chk: assert property (@(posedge clk) disable iff (rst)
    tout_flag |=> !tx_ready);

  // R8
  pin_wake_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(mode_req)) |-> (err_n == !$past(wake_in)));

  // R11
  track_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> !$fell(track_sel));
endmodule

bind txsup_top txsup_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .mode_req (mode_req),
  .guard_en (guard_en),
  .wake_in  (wake_in),
  .tx_ready (tx_ready),
  .tx_sym   (tx_sym),
  .err_n    (err_n),
  .track_sel(track_sel),
  .tout_flag(tout_w)
);

// File: tb/txsup_top_bench.sv
module txsup_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TOUT       = 1500;

  logic clk, rst, tick_us, mode_req, tx_data, tx_en_n, guard_en, rx_data;
  logic over_temp, uv_vcc, uv_vio, wake_in, cs_n, sck;
  logic tx_ready, err_n, track_sel;
  logic [1:0] tx_sym;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // {mode_req, guard_en, tx_en_n, tx_data, exp_ready, 0, exp_sym[1:0]}
  localparam logic [7:0] VEC [12] = '{
    8'b0100_0000, 8'b1000_0001, 8'b1110_1001, 8'b1101_1001,
    8'b1100_1010, 8'b1101_1011, 8'b1100_1010, 8'b1111_1001,
    8'b1101_1001, 8'b1000_0001, 8'b1100_1010, 8'b0100_0000
  };

  txsup_top u_txsup_top (
    .clk(clk), .rst(rst), .tick_us(tick_us), .mode_req(mode_req),
    .tx_data(tx_data), .tx_en_n(tx_en_n), .guard_en(guard_en), .rx_data(rx_data),
    .over_temp(over_temp), .uv_vcc(uv_vcc), .uv_vio(uv_vio), .wake_in(wake_in),
    .cs_n(cs_n), .sck(sck), .tx_ready(tx_ready), .tx_sym(tx_sym),
    .err_n(err_n), .track_sel(track_sel)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  initial begin
    tick_us = 1'b0;
    forever begin
      @(negedge clk);
      tick_us = ~tick_us;
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic frame(input int edges);
    cs_n = 1'b0;
    wait_cyc(2);
    for (int i = 0; i < edges; i++) begin
      sck = 1'b1;
      wait_cyc(2);
      sck = 1'b0;
      wait_cyc(2);
    end
    cs_n = 1'b1;
    wait_cyc(8);
  endtask

  task automatic strap(input int ticks);
    cs_n = 1'b0;
    sck  = 1'b1;
    wait_cyc(2 * ticks);
    sck = 1'b0;
    wait_cyc(2);
    cs_n = 1'b1;
    wait_cyc(8);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R1 watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; mode_req = 1'b0; tx_data = 1'b0; tx_en_n = 1'b1; guard_en = 1'b0;
    rx_data = 1'b0; over_temp = 1'b0; uv_vcc = 1'b0; uv_vio = 1'b0; wake_in = 1'b0;
    cs_n = 1'b1; sck = 1'b0;
    wait_cyc(4);
    rst = 1'b0;
    wait_cyc(2);
    // R1 reset state
    chk("R1 ready", tx_ready, 0);
    chk("R1 sym", tx_sym, 0);
    chk("R1 err_n", err_n, 1);
    chk("R1 track", track_sel, 0);

    // R8 wake shown while mode_req low
    wake_in = 1'b1; wait_cyc(4);
    chk("R8 wake low", err_n, 0);
    wake_in = 1'b0; wait_cyc(4);
    chk("R8 wake clear", err_n, 1);

    // R2 R3 R4 vector walk
    foreach (VEC[i]) begin
      mode_req = VEC[i][7]; guard_en = VEC[i][6]; tx_en_n = VEC[i][5];
      tx_data = VEC[i][4]; rx_data = VEC[i][4];
      wait_cyc(8);
      chk($sformatf("R2 vec%0d ready", i), tx_ready, VEC[i][3]);
      chk($sformatf("R3 R4 vec%0d sym", i), tx_sym, VEC[i][1:0]);
    end

    // R6 thermal latch
    mode_req = 1'b1; guard_en = 1'b1; tx_en_n = 1'b0; tx_data = 1'b0; rx_data = 1'b0;
    wait_cyc(8);
    over_temp = 1'b1; wait_cyc(8);
    chk("R6 hot blocks", tx_ready, 0);
    over_temp = 1'b0; wait_cyc(8);
    chk("R6 stays while enabled", tx_ready, 0);
    tx_en_n = 1'b1; wait_cyc(8);
    chk("R6 cleared", tx_ready, 1);
    chk("R9 latched after thermal", err_n, 0);
    frame(16);
    chk("R9 good frame clears", err_n, 1);

    // R5 timeout
    tx_en_n = 1'b0; wait_cyc(2 * (TOUT - 30));
    chk("R5 before limit", tx_ready, 1);
    chk("R5 sym data0", tx_sym, 2);
    wait_cyc(2 * 60);
    chk("R5 after limit", tx_ready, 0);
    chk("R5 sym idle", tx_sym, 1);
    tx_en_n = 1'b1; wait_cyc(8);
    chk("R5 release", tx_ready, 1);
    frame(16);
    chk("R9 clear after timeout", err_n, 1);

    // R7 bus error
    tx_en_n = 1'b0; tx_data = 1'b0; rx_data = 1'b0; wait_cyc(8);
    rx_data = 1'b1; wait_cyc(8);
    chk("R7 no edge no error", err_n, 1);
    tx_data = 1'b1; wait_cyc(8);
    chk("R7 match", err_n, 1);
    tx_data = 1'b0; wait_cyc(8);
    chk("R7 mismatch", err_n, 0);
    chk("R7 ready kept", tx_ready, 1);
    chk("R7 sym kept", tx_sym, 2);
    tx_en_n = 1'b1; rx_data = 1'b0; wait_cyc(8);
    frame(16);
    chk("R9 clear after bus error", err_n, 1);

    // R13 undervoltage
    uv_vcc = 1'b1; wait_cyc(8);
    chk("R13 ready", tx_ready, 0);
    chk("R13 sym", tx_sym, 0);
    chk("R13 err", err_n, 0);
    uv_vcc = 1'b0; wait_cyc(8);
    frame(16);
    chk("R9 clear after uv", err_n, 1);
    chk("R13 ready back", tx_ready, 1);

    // R10 wrong edge count
    frame(15);
    chk("R10 short frame", err_n, 0);
    frame(16);
    chk("R10 recovered", err_n, 1);

    // R11 strap too short, then long enough
    strap(50);
    chk("R11 short strap", track_sel, 0);
    chk("R10 sck high at cs edge", err_n, 0);
    frame(16);
    chk("R10 clear", err_n, 1);
    strap(250);
    chk("R11 track selected", track_sel, 1);
    chk("R12 no leftover error", err_n, 1);

    // R12 track mode hold
    over_temp = 1'b1; wait_cyc(1);
    over_temp = 1'b0; wait_cyc(5);
    chk("R12 pulse held", err_n, 0);
    wait_cyc(40);
    chk("R12 released", err_n, 1);
    uv_vio = 1'b1; wait_cyc(8);
    chk("R13 uv_vio err", err_n, 0);
    chk("R13 uv_vio ready", tx_ready, 0);
    uv_vio = 1'b0; wait_cyc(40);
    chk("R12 clears without frame", err_n, 1);
    chk("R11 still track", track_sel, 1);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule